// File: doc/BRIEF.md
# Multiple-Header Error Log Queue

This block holds the error-logging state of an advanced error reporting capability: the pointer to the first uncorrectable error, the four-dword header log and the four-dword prefix log. When several uncorrectable errors arrive before software services the first one, it keeps the later ones in a small circular buffer. It brings each one forward only after software has cleared the status bit of the error currently on display.

An error source presents a record request. The request carries a one-hot status vector, the header and prefix dwords, and flags that say whether each of them is valid. A neighbouring status register supplies its current value, and on each software write it passes in the value left after that write. The block then pops or discards queued records, or re-asserts their status bits through a one-cycle set pulse. A one-cycle overflow pulse tells the reporting logic to raise a correctable header-log-overflow error. All outputs are registered and change one clock edge after the request or write.

Top module: `err_hdr_log_queue`

## Requirements
- R1: A record request whose status vector is zero, or has more than one bit set, changes no log output and queues nothing.
- R2: A record that is not queued loads `fep_o` with the bit index of its one-hot status. It also loads `hdr_log_o` with the header dwords, each byte-reversed: dword k sits in bits [32k+31:32k], and its byte 0 moves to byte 3. All of this is visible one edge after the request.
- R3: A loaded record whose header-valid flag is clear leaves `hdr_log_o` all zero.
- R4: `pfx_log_o` is loaded (byte-reversed like the header) and `pfx_present_o` is set only when the record's prefix flag and `pfx_supported_i` are both high. Otherwise both are zero.
- R5: When `mhr_en_i` is high and bit `fep_o` of `uncor_sts_i` is set, a new record goes to the queue and the visible log does not change.
- R6: A record that must be queued while DEPTH records are already waiting is dropped, and `ovf_o` pulses high for one cycle.
- R7: A status write that clears bit `fep_o` pops the oldest record into the log when recording is enabled and the queue holds records. The pop is in arrival order. `sts_set_o` then pulses the OR of the status bits of every queued record, the popped one included.
- R8: A status write that clears bit `fep_o` while the queue is empty or recording is disabled zeroes `fep_o`, both logs and `pfx_present_o`, and pulses no set bits.
- R9: A status write that leaves bit `fep_o` set while recording is enabled pulses `sts_set_o` with the OR of all queued status bits and leaves the queue intact.
- R10: A status write that leaves bit `fep_o` set while recording is disabled discards every queued record.
- R11: `mhr_cap_o` is high when DEPTH is above zero. With `mhr_en_i` low, every valid record overwrites the log, whatever the state of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mhr_en_i | input | 1 | Multiple-header recording enable |
| pfx_supported_i | input | 1 | End-to-end prefix support advertised |
| rec_valid_i | input | 1 | Record-error request strobe |
| rec_status_i | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr_i | input | 128 | Header dwords, dword k in bits [32k+31:32k] |
| rec_pfx_i | input | 128 | Prefix dwords, same layout |
| rec_hdr_vld_i | input | 1 | Header dwords are valid |
| rec_pfx_vld_i | input | 1 | Prefix dwords are present |
| uncor_sts_i | input | 32 | Current uncorrectable status register value |
| sts_wr_i | input | 1 | Software wrote the status register |
| sts_val_i | input | 32 | Status register value after that write |
| fep_o | output | 5 | First-error pointer |
| hdr_log_o | output | 128 | Header log |
| pfx_log_o | output | 128 | Prefix log |
| pfx_present_o | output | 1 | Prefix log holds a valid prefix |
| sts_set_o | output | 32 | One-cycle pulse of status bits to re-assert |
| ovf_o | output | 1 | One-cycle header-log-overflow pulse |
| mhr_cap_o | output | 1 | Multiple-header recording capability |

## Verification
Records are sent with a valid header and with an invalid one, and with the prefix flag set or clear while prefix support is on or off. This separates the byte-reversed load from the zero-fill paths. Non-one-hot and zero status vectors show that malformed requests are dropped. A three-record sequence is drained by writes that alternately keep and clear the first-error bit, which tells a pop apart from a re-assertion and checks arrival order. A full queue plus one extra record separates a stored entry from a dropped one, and toggling the enable before a write separates discarding the queue from keeping it.

// File: rtl/ehlq_pkg.sv
`timescale 1ns/1ps
package ehlq_pkg;
  localparam int STS_W   = 32;
  localparam int IDX_W   = $clog2(STS_W);
  localparam int DW_W    = 32;
  localparam int N_DW    = 4;
  localparam int LOG_W   = DW_W * N_DW;
  localparam int N_BYTES = DW_W / 8;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             hdr_vld;
    logic             pfx_vld;
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
  } err_rec_t;

  // reverse byte order inside each dword
  function automatic logic [LOG_W-1:0] dw_bswap(input logic [LOG_W-1:0] d);
    logic [LOG_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_DW; k++)
      for (int b = 0; b < N_BYTES; b++)
        r[k*DW_W + b*8 +: 8] = d[k*DW_W + (N_BYTES-1-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] oh_index(input logic [STS_W-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < STS_W; i++)
      if (s[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/ehlq_fifo.sv
`timescale 1ns/1ps
module ehlq_fifo
  import ehlq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  err_rec_t         push_rec_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output err_rec_t         head_rec_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [STS_W-1:0] sts_or_o
);
  if (DEPTH == 0) begin : g_none
    assign head_rec_o = '0;
    assign full_o     = 1'b1;
    assign empty_o    = 1'b1;
    assign sts_or_o   = '0;
  end else begin : g_buf
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    err_rec_t         mem [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o     = (cnt_q == CNT_W'(DEPTH));
    assign empty_o    = (cnt_q == '0);
    assign head_rec_o = mem[rd_q];

    always_ff @(posedge clk_i) begin
      if (push_i && !full_o && !flush_i) mem[wr_q] <= push_rec_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        wr_q  <= '0;
        rd_q  <= '0;
        cnt_q <= '0;
      end else if (flush_i) begin
        vld_q <= '0;
        wr_q  <= '0;
        rd_q  <= '0;
        cnt_q <= '0;
      end else if (push_i && !full_o) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= nxt(wr_q);
        cnt_q       <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= nxt(rd_q);
        cnt_q       <= cnt_q - 1'b1;
      end
    end

    always_comb begin
      sts_or_o = '0;
      for (int i = 0; i < DEPTH; i++)
        if (vld_q[i]) sts_or_o[mem[i].idx] = 1'b1;
    end
  end
endmodule

// File: rtl/ehlq_log_regs.sv
`timescale 1ns/1ps
module ehlq_log_regs
  import ehlq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  err_rec_t         rec_i,
  input  logic             clear_i,
  input  logic             pfx_sup_i,
  output logic [IDX_W-1:0] fep_o,
  output logic [LOG_W-1:0] hdr_o,
  output logic [LOG_W-1:0] pfx_o,
  output logic             pfx_present_o
);
  logic use_pfx;
  assign use_pfx = rec_i.pfx_vld && pfx_sup_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fep_o         <= '0;
      hdr_o         <= '0;
      pfx_o         <= '0;
      pfx_present_o <= 1'b0;
    end else if (load_i) begin
      fep_o         <= rec_i.idx;
      hdr_o         <= rec_i.hdr_vld ? dw_bswap(rec_i.hdr) : '0;
      pfx_o         <= use_pfx ? dw_bswap(rec_i.pfx) : '0;
      pfx_present_o <= use_pfx;
    end else if (clear_i) begin
      fep_o         <= '0;
      hdr_o         <= '0;
      pfx_o         <= '0;
      pfx_present_o <= 1'b0;
    end
  end
endmodule

// File: rtl/err_hdr_log_queue.sv
`timescale 1ns/1ps
module err_hdr_log_queue
  import ehlq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mhr_en_i,
  input  logic                  pfx_supported_i,
  input  logic                  rec_valid_i,
  input  logic [STS_W-1:0]      rec_status_i,
  input  logic [LOG_W-1:0]      rec_hdr_i,
  input  logic [LOG_W-1:0]      rec_pfx_i,
  input  logic                  rec_hdr_vld_i,
  input  logic                  rec_pfx_vld_i,
  input  logic [STS_W-1:0]      uncor_sts_i,
  input  logic                  sts_wr_i,
  input  logic [STS_W-1:0]      sts_val_i,
  output logic [IDX_W-1:0]      fep_o,
  output logic [LOG_W-1:0]      hdr_log_o,
  output logic [LOG_W-1:0]      pfx_log_o,
  output logic                  pfx_present_o,
  output logic [STS_W-1:0]      sts_set_o,
  output logic                  ovf_o,
  output logic                  mhr_cap_o
);
  localparam bit HAS_Q = (DEPTH > 0);

  err_rec_t         new_rec, head_rec, load_rec;
  logic             mhr_eff, rec_ok, queue_it, push, ovf_d;
  logic             fe_kept, clr, pop, log_clear, flush, load;
  logic             q_full, q_empty;
  logic [STS_W-1:0] q_sts_or, set_d;

  assign mhr_cap_o = HAS_Q;
  assign mhr_eff   = mhr_en_i && HAS_Q;

  assign rec_ok = rec_valid_i && (rec_status_i != '0) &&
                  ((rec_status_i & (rec_status_i - 1'b1)) == '0);

  always_comb begin
    new_rec.idx     = oh_index(rec_status_i);
    new_rec.hdr_vld = rec_hdr_vld_i;
    new_rec.pfx_vld = rec_pfx_vld_i;
    new_rec.hdr     = rec_hdr_i;
    new_rec.pfx     = rec_pfx_i;
  end

  // record path: queue behind a still-pending first error
  assign queue_it = rec_ok && mhr_eff && uncor_sts_i[fep_o];
  assign push     = queue_it && !q_full;
  assign ovf_d    = queue_it && q_full;

  // status-write path
  assign fe_kept   = sts_val_i[fep_o];
  assign clr       = sts_wr_i && !fe_kept;
  assign pop       = clr && mhr_eff && !q_empty;
  assign log_clear = clr && !pop;
  assign flush     = sts_wr_i && fe_kept && !mhr_eff;
  assign set_d     = (pop || (sts_wr_i && fe_kept && mhr_eff)) ? q_sts_or : '0;

  assign load     = (rec_ok && !queue_it) || pop;
  assign load_rec = pop ? head_rec : new_rec;

  ehlq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_rec_i (new_rec),
    .pop_i      (pop),
    .flush_i    (flush),
    .head_rec_o (head_rec),
    .full_o     (q_full),
    .empty_o    (q_empty),
    .sts_or_o   (q_sts_or)
  );

  ehlq_log_regs u_log (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .rec_i         (load_rec),
    .clear_i       (log_clear),
    .pfx_sup_i     (pfx_supported_i),
    .fep_o         (fep_o),
    .hdr_o         (hdr_log_o),
    .pfx_o         (pfx_log_o),
    .pfx_present_o (pfx_present_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o     <= 1'b0;
      sts_set_o <= '0;
    end else begin
      ovf_o     <= ovf_d;
      sts_set_o <= set_d;
    end
  end
endmodule

// File: rtl/ehlq_checker.sv
`timescale 1ns/1ps
module ehlq_checker
  import ehlq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_valid_i,
  input logic             sts_wr_i,
  input logic             pfx_supported_i,
  input logic [IDX_W-1:0] fep_o,
  input logic [LOG_W-1:0] hdr_log_o,
  input logic [LOG_W-1:0] pfx_log_o,
  input logic             pfx_present_o,
  input logic [STS_W-1:0] sts_set_o,
  input logic             ovf_o
);
  a_r6_ovf_after_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(rec_valid_i));

  a_r7_set_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_set_o != '0) |-> $past(sts_wr_i));

  a_r4_pfx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pfx_present_o |-> (pfx_log_o == '0));

  a_r4_present_needs_sup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pfx_present_o) |-> $past(pfx_supported_i));

  a_r2_log_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_valid_i && !sts_wr_i) |=> ($stable(fep_o) && $stable(hdr_log_o)));
endmodule

bind err_hdr_log_queue ehlq_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rec_valid_i     (rec_valid_i),
  .sts_wr_i        (sts_wr_i),
  .pfx_supported_i (pfx_supported_i),
  .fep_o           (fep_o),
  .hdr_log_o       (hdr_log_o),
  .pfx_log_o       (pfx_log_o),
  .pfx_present_o   (pfx_present_o),
  .sts_set_o       (sts_set_o),
  .ovf_o           (ovf_o)
);

// File: tb/err_hdr_log_queue_tb.sv
`timescale 1ns/1ps
module err_hdr_log_queue_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mhr_en = 1'b0, pfx_sup = 1'b0;
  logic         rec_valid = 1'b0, hdr_vld = 1'b0, pfx_vld = 1'b0;
  logic [31:0]  rec_status = '0, uncor_sts = '0, sts_val = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic         sts_wr = 1'b0;
  logic [4:0]   fep;
  logic [127:0] hdr_log, pfx_log;
  logic         pfx_present, ovf, mhr_cap;
  logic [31:0]  sts_set;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_hdr_log_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mhr_en_i(mhr_en), .pfx_supported_i(pfx_sup),
    .rec_valid_i(rec_valid), .rec_status_i(rec_status), .rec_hdr_i(rec_hdr),
    .rec_pfx_i(rec_pfx), .rec_hdr_vld_i(hdr_vld), .rec_pfx_vld_i(pfx_vld),
    .uncor_sts_i(uncor_sts), .sts_wr_i(sts_wr), .sts_val_i(sts_val),
    .fep_o(fep), .hdr_log_o(hdr_log), .pfx_log_o(pfx_log),
    .pfx_present_o(pfx_present), .sts_set_o(sts_set), .ovf_o(ovf),
    .mhr_cap_o(mhr_cap)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input logic [7:0] tag);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = {tag, 8'(k + 1), 8'hA5, 8'h3C};
    return r;
  endfunction

  function automatic logic [127:0] rev(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = d[k*32 +: 32];
      r[k*32 +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
    end
    return r;
  endfunction

  task automatic do_rec(input logic [31:0] st, input logic [7:0] tag,
                        input logic hv, input logic pv);
    @(negedge clk);
    rec_valid = 1'b1; rec_status = st; rec_hdr = pat(tag); rec_pfx = pat(~tag);
    hdr_vld = hv; pfx_vld = pv;
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [31:0] v);
    @(negedge clk);
    sts_wr = 1'b1; sts_val = v;
    @(negedge clk);
    sts_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset fep", 128'(fep), 128'd0);
    chk("R8 reset hdr", hdr_log, '0);
    chk("R8 reset pfx", pfx_log, '0);
    chk("R6 reset ovf", 128'(ovf), 128'd0);
    chk("R11 cap", 128'(mhr_cap), 128'd1);
  endtask

  task automatic t_direct;
    uncor_sts = '0; mhr_en = 1'b0; pfx_sup = 1'b0;
    do_rec(32'h10, 8'h11, 1'b1, 1'b0);
    chk("R2 fep", 128'(fep), 128'd4);
    chk("R2 hdr swapped", hdr_log, rev(pat(8'h11)));
    chk("R4 no prefix", 128'(pfx_present), 128'd0);
    do_rec(32'h200, 8'h22, 1'b0, 1'b0);
    chk("R3 fep", 128'(fep), 128'd9);
    chk("R3 hdr zero", hdr_log, '0);
  endtask

  task automatic t_prefix;
    pfx_sup = 1'b1;
    do_rec(32'h4, 8'h33, 1'b1, 1'b1);
    chk("R4 prefix loaded", pfx_log, rev(pat(~8'h33)));
    chk("R4 present set", 128'(pfx_present), 128'd1);
    pfx_sup = 1'b0;
    do_rec(32'h8, 8'h34, 1'b1, 1'b1);
    chk("R4 unsupported zero", pfx_log, '0);
    chk("R4 present clear", 128'(pfx_present), 128'd0);
  endtask

  task automatic t_bad;
    do_rec(32'h3, 8'h44, 1'b1, 1'b0);
    chk("R1 two bits fep", 128'(fep), 128'd3);
    chk("R1 two bits hdr", hdr_log, rev(pat(8'h34)));
    do_rec(32'h0, 8'h45, 1'b1, 1'b0);
    chk("R1 zero status hdr", hdr_log, rev(pat(8'h34)));
  endtask

  task automatic t_queue;
    mhr_en = 1'b1; uncor_sts = '0;
    do_rec(32'h10, 8'hA0, 1'b1, 1'b0);
    chk("R2 first load", 128'(fep), 128'd4);
    uncor_sts = 32'h10;
    do_rec(32'h1000, 8'hB0, 1'b1, 1'b0);
    do_rec(32'h0010_0000, 8'hC0, 1'b1, 1'b0);
    chk("R5 log kept fep", 128'(fep), 128'd4);
    chk("R5 log kept hdr", hdr_log, rev(pat(8'hA0)));
    do_wr(32'h0010_1000);
    chk("R7 set pulse", 128'(sts_set), 128'h0010_1000);
    chk("R7 pop fep", 128'(fep), 128'd12);
    chk("R7 pop hdr", hdr_log, rev(pat(8'hB0)));
    @(negedge clk);
    chk("R7 pulse ends", 128'(sts_set), 128'd0);
    do_wr(32'h1000);
    chk("R9 reassert", 128'(sts_set), 128'h0010_0000);
    chk("R9 fep kept", 128'(fep), 128'd12);
    do_wr(32'h0);
    chk("R7 second pop fep", 128'(fep), 128'd20);
    chk("R7 second pop set", 128'(sts_set), 128'h0010_0000);
    do_wr(32'h0);
    chk("R8 cleared fep", 128'(fep), 128'd0);
    chk("R8 cleared hdr", hdr_log, '0);
    chk("R8 no set", 128'(sts_set), 128'd0);
  endtask

  task automatic t_overflow;
    uncor_sts = 32'h1;
    for (int i = 1; i <= 8; i++) begin
      do_rec(32'(1) << i, 8'(i), 1'b1, 1'b0);
      chk("R6 no ovf while room", 128'(ovf), 128'd0);
    end
    do_rec(32'h200, 8'h09, 1'b1, 1'b0);
    chk("R6 ovf pulse", 128'(ovf), 128'd1);
    @(negedge clk);
    chk("R6 ovf one cycle", 128'(ovf), 128'd0);
    chk("R5 fep unchanged", 128'(fep), 128'd0);
    do_wr(32'h0);
    chk("R6 dropped entry absent", 128'(sts_set), 128'h1FE);
    chk("R7 oldest first", 128'(fep), 128'd1);
  endtask

  task automatic t_flush;
    mhr_en = 1'b0;
    do_wr(32'h2);
    chk("R10 no set when disabled", 128'(sts_set), 128'd0);
    mhr_en = 1'b1;
    do_wr(32'h0);
    chk("R10 queue empty after flush", 128'(fep), 128'd0);
    chk("R10 no set after flush", 128'(sts_set), 128'd0);
  endtask

  task automatic t_disabled;
    mhr_en = 1'b0;
    do_rec(32'h40, 8'h66, 1'b1, 1'b0);
    uncor_sts = 32'h40;
    do_rec(32'h80, 8'h77, 1'b1, 1'b0);
    chk("R11 overwrite fep", 128'(fep), 128'd7);
    chk("R11 overwrite hdr", hdr_log, rev(pat(8'h77)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_prefix();
    t_bad();
    t_queue();
    t_overflow();
    t_flush();
    t_disabled();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule